// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a logical address, given as a segment number and an offset within that segment, into a physical address. It holds a small table in which every segment has a base address and a limit. Software fills the table through a write port. The write port carries an entry index, a base and a limit.

For each request, the block selects the table entry named by the segment number and checks the offset against that entry's limit. A legal access returns the base plus the offset. Any other access raises a segmentation fault and drives no address.

The default table has four entries, one for each of the code, data, stack and heap segments. When the block is built with one entry, it works as a plain base-and-limit relocation unit. Every result is registered, so each response appears one clock after its request.

Top module: `seg_xlat`

## Requirements
- R1: While reset is held and after it is released, rsp_valid, rsp_fault and rsp_addr are 0. Every table entry resets to base 0 and limit 0, so an access to any entry after reset faults.
- R2: When cfg_we is high, entry cfg_sel takes cfg_base and cfg_limit at the clock edge. Requests from the next cycle on use the new values. A request in the same cycle as the write uses the entry's previous contents.
- R3: A table write with cfg_sel >= NUM_SEG is ignored, and every entry keeps its contents.
- R4: An access whose segment is in the table and whose offset is strictly below that entry's limit is legal. It returns rsp_fault = 0 and rsp_addr = (base + offset) mod 2^PA_W. For example, base 12000 with limit 3000 maps offset 500 to 12500.
- R5: An access whose offset is greater than or equal to the limit faults. This includes an offset exactly equal to the limit. A limit of 0 makes every access to that entry fault. For example, base 4000 with limit 8000 faults on offset 9000.
- R6: An access with req_seg >= NUM_SEG faults, whatever its offset.
- R7: Whenever rsp_fault is 1, rsp_addr is 0.
- R8: rsp_valid is 1 in exactly the cycle after a cycle with req_valid high. When rsp_valid is 0, rsp_fault and rsp_addr are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | SEG_W | Entry index to write |
| cfg_base | input | PA_W | Base address to store |
| cfg_limit | input | OFF_W | Segment length to store |
| req_valid | input | 1 | A translation request is present |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset within the segment |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_fault | output | 1 | Segmentation fault for that request |
| rsp_addr | output | PA_W | Physical address, 0 on a fault |

## Verification
Every response is due exactly one clock edge after its request. A table write is visible to requests from the edge after the write, and not to a request in the same cycle. The bench drives each request and write on a falling edge and reads the outputs on the next falling edge, one rising edge later. Before it applies a write to its own copy of the table, it computes the expected result from the table as it stood, so that same-cycle write-and-request cases are judged against the old contents.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  // Kind of result held in the output register.
  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_OK    = 2'd1,
    RSP_FAULT = 2'd2
  } rsp_kind_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 3,
  parameter int OFF_W   = 16,
  parameter int PA_W    = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W-1:0] rd_limit,
  output logic             rd_hit
);

  logic [PA_W-1:0]  base_q [NUM_SEG];
  logic [OFF_W-1:0] lim_q  [NUM_SEG];

  // One base/limit register pair per entry; an index past the table matches none.
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        lim_q[g]  <= '0;
      end else if (wr_en && (wr_idx == SEG_W'(g))) begin
        base_q[g] <= wr_base;
        lim_q[g]  <= wr_limit;
      end
    end
  end

  // The read select is an AND-OR mux, so an out-of-range index returns zeros and no hit.
  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    rd_hit   = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_idx == SEG_W'(i)) begin
        rd_base  = base_q[i];
        rd_limit = lim_q[i];
        rd_hit   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input  logic             hit,
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W-1:0] limit,
  input  logic [OFF_W-1:0] off,
  output logic             ok,
  output logic [PA_W-1:0]  addr
);

  // Strict bound: an offset equal to the limit is already outside.
  function automatic logic fits(input logic [OFF_W-1:0] o, input logic [OFF_W-1:0] l);
    return o < l;
  endfunction

  // Relocation sum, wrapping at the physical address width.
  function automatic logic [PA_W-1:0] relocate(input logic [PA_W-1:0] b, input logic [OFF_W-1:0] o);
    return b + PA_W'(o);
  endfunction

  always_comb begin
    ok   = hit && fits(off, limit);
    addr = ok ? relocate(base, off) : '0;
  end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 3,
  parameter int OFF_W   = 16,
  parameter int PA_W    = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_sel,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFF_W-1:0] cfg_limit,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_addr
);

  localparam int SEG_SPAN = 1 << SEG_W;

  initial begin
    if (NUM_SEG < 1 || NUM_SEG > SEG_SPAN) $error("NUM_SEG must lie in 1..2**SEG_W");
    if (PA_W < OFF_W) $error("PA_W must not be narrower than OFF_W");
  end

  // Named internal events, brought out for the checker.
  logic             xl_hit;
  logic [PA_W-1:0]  xl_base;
  logic [OFF_W-1:0] xl_limit;
  logic             xl_ok;
  logic [PA_W-1:0]  xl_addr;

  seg_table #(
    .NUM_SEG (NUM_SEG),
    .SEG_W   (SEG_W),
    .OFF_W   (OFF_W),
    .PA_W    (PA_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_sel),
    .wr_base  (cfg_base),
    .wr_limit (cfg_limit),
    .rd_idx   (req_seg),
    .rd_base  (xl_base),
    .rd_limit (xl_limit),
    .rd_hit   (xl_hit)
  );

  seg_check #(
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
  ) u_check (
    .hit   (xl_hit),
    .base  (xl_base),
    .limit (xl_limit),
    .off   (req_off),
    .ok    (xl_ok),
    .addr  (xl_addr)
  );

  rsp_kind_e       kind_d, kind_q;
  logic [PA_W-1:0] addr_q;

  always_comb begin
    if (!req_valid)  kind_d = RSP_IDLE;
    else if (xl_ok)  kind_d = RSP_OK;
    else             kind_d = RSP_FAULT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RSP_IDLE;
      addr_q <= '0;
    end else begin
      kind_q <= kind_d;
      addr_q <= (kind_d == RSP_OK) ? xl_addr : '0;
    end
  end

  assign rsp_valid = (kind_q != RSP_IDLE);
  assign rsp_fault = (kind_q == RSP_FAULT);
  assign rsp_addr  = addr_q;

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter int SEG_W = 3,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_off,
  input logic             xl_hit,
  input logic [OFF_W-1:0] xl_limit,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_addr
);

  p_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_addr == '0));

  p_noaddr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_addr == '0);

  p_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xl_hit) |=> rsp_fault);

  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xl_hit && req_off >= xl_limit) |=> rsp_fault);

  p_zero_lim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xl_hit && xl_limit == '0) |=> rsp_fault);

  p_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xl_hit && req_off < xl_limit) |=> (rsp_valid && !rsp_fault));

endmodule

bind seg_xlat seg_xlat_chk #(
  .SEG_W (SEG_W),
  .OFF_W (OFF_W),
  .PA_W  (PA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_off   (req_off),
  .xl_hit    (xl_hit),
  .xl_limit  (xl_limit),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_addr  (rsp_addr)
);

// File: tb/seg_xlat_tb.sv
`timescale 1ns/1ps
module seg_xlat_tb;

  localparam int NUM_SEG = 4;
  localparam int SEG_W   = 3;
  localparam int OFF_W   = 16;
  localparam int PA_W    = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [SEG_W-1:0] cfg_sel = '0;
  logic [PA_W-1:0]  cfg_base = '0;
  logic [OFF_W-1:0] cfg_limit = '0;
  logic             req_valid = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic             rsp_valid, rsp_fault;
  logic [PA_W-1:0]  rsp_addr;

  always #2.5 clk = ~clk;

  seg_xlat #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .req_valid(req_valid),
    .req_seg(req_seg), .req_off(req_off), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
  );

  int checks = 0;
  int errors = 0;
  int m_base [NUM_SEG];
  int m_lim  [NUM_SEG];
  bit done = 1'b0;

  function automatic bit exp_fault(int seg, int off);
    if (seg >= NUM_SEG) return 1'b1;
    return !(off < m_lim[seg]);
  endfunction

  function automatic int exp_addr(int seg, int off);
    if (exp_fault(seg, off)) return 0;
    return (m_base[seg] + off) % (1 << PA_W);
  endfunction

  task automatic check(bit cond, string tag, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge; check the response one rising edge later.
  task automatic step(bit we, int sel, int base, int lim, bit rv, int seg, int off, string tag);
    bit f;
    int a;
    f = exp_fault(seg, off);
    a = exp_addr(seg, off);
    cfg_we = we; cfg_sel = SEG_W'(sel); cfg_base = PA_W'(base); cfg_limit = OFF_W'(lim);
    req_valid = rv; req_seg = SEG_W'(seg); req_off = OFF_W'(off);
    if (we && sel < NUM_SEG) begin
      m_base[sel] = base % (1 << PA_W);
      m_lim[sel]  = lim;
    end
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    if (rv) begin
      check(rsp_valid == 1'b1, {tag, " R8 valid"}, int'(rsp_valid), 1);
      check(rsp_fault == f, {tag, " fault"}, int'(rsp_fault), int'(f));
      check(int'(rsp_addr) == a, {tag, " addr"}, int'(rsp_addr), a);
    end else begin
      check(!rsp_valid && !rsp_fault && rsp_addr == '0, {tag, " R8 idle"},
            int'(rsp_valid) + int'(rsp_fault) + int'(rsp_addr), 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    for (int i = 0; i < NUM_SEG; i++) begin
      m_base[i] = 0;
      m_lim[i]  = 0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(!rsp_valid && !rsp_fault && rsp_addr == '0, "R1 in reset",
          int'(rsp_valid) + int'(rsp_fault), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: cleared table faults everywhere
    for (int s = 0; s < NUM_SEG; s++) step(0, 0, 0, 0, 1, s, 0, "R1 reset table");
    // R2: table writes, then lookups
    step(1, 0, 5000, 2000, 0, 0, 0, "R2 wr code");
    step(1, 1, 8000, 1000, 0, 0, 0, "R2 wr data");
    step(1, 2, 12000, 3000, 0, 0, 0, "R2 wr stack");
    step(1, 3, 4000, 8000, 0, 0, 0, "R2 wr heap");
    step(0, 0, 0, 0, 1, 2, 500, "R4 stack 12500");
    check(int'(rsp_addr) == 12500, "R4 literal", int'(rsp_addr), 12500);
    step(0, 0, 0, 0, 1, 3, 1000, "R4 heap 5000");
    step(0, 0, 0, 0, 1, 3, 9000, "R5 heap over");
    step(0, 0, 0, 0, 1, 3, 8000, "R5 equal limit");
    step(0, 0, 0, 0, 1, 3, 7999, "R4 last legal");
    step(0, 0, 0, 0, 1, 0, 0, "R4 offset zero");
    // R2: same-cycle write and request sees old contents, next cycle sees new
    step(1, 1, 70000, 50, 1, 1, 900, "R2 same cycle old");
    step(0, 0, 0, 0, 1, 1, 900, "R2 after write new");
    step(0, 0, 0, 0, 1, 1, 49, "R2 new legal");
    // R5: zero limit
    step(1, 0, 100, 0, 0, 0, 0, "R5 wr zero lim");
    step(0, 0, 0, 0, 1, 0, 0, "R5 zero lim off0");
    step(0, 0, 0, 0, 1, 0, 65535, "R5 zero lim max");
    // R6: segments outside the table
    for (int s = NUM_SEG; s < (1 << SEG_W); s++) step(0, 0, 0, 0, 1, s, 0, "R6 outside");
    // R3: out-of-range writes leave every entry unchanged
    step(1, 5, 999, 65535, 0, 0, 0, "R3 wr ignored");
    step(1, 7, 1, 65535, 1, 2, 2999, "R3 wr ignored2");
    for (int s = 0; s < NUM_SEG; s++) step(0, 0, 0, 0, 1, s, m_lim[s] > 0 ? m_lim[s] - 1 : 0, "R3 entries kept");
    // R4: wraparound at the physical width
    step(1, 2, (1 << PA_W) - 10, 100, 0, 0, 0, "R4 wr wrap");
    step(0, 0, 0, 0, 1, 2, 20, "R4 wrap addr");
    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int kind, sel, seg, off;
      kind = int'($urandom_range(0, 9));
      sel  = int'($urandom_range(0, (1 << SEG_W) - 1));
      seg  = int'($urandom_range(0, (1 << SEG_W) - 1));
      if (seg < NUM_SEG && $urandom_range(0, 1) == 1)
        off = m_lim[seg] + int'($urandom_range(0, 2)) - 1;
      else
        off = int'($urandom_range(0, (1 << OFF_W) - 1));
      if (off < 0) off = 0;
      if (off > (1 << OFF_W) - 1) off = (1 << OFF_W) - 1;
      step(kind < 2, sel, int'($urandom_range(0, (1 << PA_W) - 1)),
           int'($urandom_range(0, (1 << OFF_W) - 1)),
           kind != 9, seg, off, "R4 R5 R6 random");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule